// File: doc/BRIEF.md
# Dual Adder-Accumulator with Scaling

This block is a registered arithmetic datapath for complex-valued signal processing. It has two 20-bit adder/subtractor units, one for the real part and one for the imaginary part. Each unit has its own operation code and its own accumulator register. Two 16-bit input ports (`a_in`, `b_in`) are captured into input registers. Each unit takes two operands:

- The X operand comes from a multiplexer. It is either fresh input data or the unit's own accumulator.
- The Y operand is always fresh input data.

The real unit's fresh X data can optionally be taken from an eight-stage delay line. This lines up data that bypassed an external pipelined stage, such as the butterfly inputs in an FFT.

Each 20-bit result is reduced to a 16-bit output word. A shared scaling code picks one of eight windows of the result. A single registered overflow flag reports two conditions:

- an adder wrapped at 20 bits, or
- a result has significant bits above the chosen window.

Each output word can be tri-stated asynchronously by its own enable.

The latency is two clock edges. Data and controls driven before edge k are captured at edge k, and the result is on the outputs after edge k+1. All control inputs are registered together with the data, so a control change applies to the data captured at the same edge.

Top module: `cplx_accum_dual`

## Requirements
- R1: Data and controls present before clock edge k are captured at edge k. The resulting output words and overflow flag appear after edge k+1, and not after edge k.
- R2: `a_ce_n` and `b_ce_n` are active-low enables of the A and B input registers. While an enable is 1, its register keeps its previous value.
- R3: The operation codes use this encoding: 00 = X+Y, 01 = X−Y, 10 = Y−X, 11 = pass X.
  - Real unit: X is its multiplexer output and Y is the B register.
  - Imaginary unit: X is its multiplexer output (fresh data = the B register) and Y is the A register.
- R4: Input words are two's complement and are sign-extended to 20 bits before the operation. A sum of fresh inputs therefore never raises the flag under scale code 0.
- R5: `fb_sel` = 1 makes each unit's X operand its own accumulator. `fb_sel` = 0 makes X fresh data. The accumulator loads every unit result, except on a clear.
- R6: A registered `acc_clr` = 1 zeroes both accumulators instead of loading the result, so the next feedback operand is 0. The output word of that cycle still shows the computed result.
- R7: With `dly_sel` = 1, the real unit's fresh X is the A register value from eight cycles earlier. The imaginary unit is unaffected.
- R8: Operation codes, clear, feedback select, scale code and delay select are registered. A change applies to data captured at the same edge.
- R9: Scale code s picks bits (19−s) downward from the 20-bit result, for both units.
  - Codes 0 to 4 give 16 bits: bits 19:4, 18:3, 17:2, 16:1 and 15:0.
  - Codes 5, 6 and 7 give bits 14:0, 13:0 and 12:0, with the upper 1, 2 and 3 output bits set to 0.
- R10: `ovf` is 1 when either result has bits 19 down to (19−s) not all equal, which means the value does not fit the window.
- R11: `ovf` is also 1 when either unit's true sum does not fit 20-bit two's complement. The stored result wraps modulo 2^20.
- R12: `oe_re_n` = 1 or `oe_im_n` = 1 asynchronously places `out_re` or `out_im` in high impedance, without a clock edge.
- R13: After reset, every register is zero, both output words are 0 and `ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 16 | Input word A |
| b_in | input | 16 | Input word B |
| a_ce_n | input | 1 | Active-low load enable of the A register |
| b_ce_n | input | 1 | Active-low load enable of the B register |
| op_re | input | 2 | Operation code of the real unit |
| op_im | input | 2 | Operation code of the imaginary unit |
| acc_clr | input | 1 | Clear both accumulators |
| fb_sel | input | 1 | 1: X operands come from the accumulators |
| scale | input | 3 | Output window code |
| dly_sel | input | 1 | 1: real fresh X comes from the eight-stage delay line |
| oe_re_n | input | 1 | Active-high tri-state control of out_re |
| oe_im_n | input | 1 | Active-high tri-state control of out_im |
| out_re | output | 16 | Windowed real result |
| out_im | output | 16 | Windowed imaginary result |
| ovf | output | 1 | Overflow flag |

## Verification
The 20-bit wrap is the hardest condition to reach from the ports. Fresh 16-bit operands can never produce it, so the bench clears the accumulators with feedback enabled and then adds 0x7FFF once per cycle. The flag must be 0 on the sixteenth sum, 1 on the seventeenth (where the sum wraps negative) and 0 again after that. The bench also checks that clear has priority over feedback by asserting clear during an accumulation: the sum of that cycle must still appear on the output, and the sum of the next cycle must restart from zero. The eight-cycle delay path is reached by streaming a distinct word every cycle and comparing each output against the word sent nine edges earlier.

// File: rtl/cad_pkg.sv
package cad_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_RSUB = 2'd2,
        OP_PASS = 2'd3
    } cad_op_e;
endpackage

// File: rtl/cad_addsub.sv
module cad_addsub
    import cad_pkg::*;
#(
    parameter int ACC_W = 20
) (
    input  cad_op_e          op,
    input  logic [ACC_W-1:0] x,
    input  logic [ACC_W-1:0] y,
    output logic [ACC_W-1:0] res,
    output logic             wrap
);
    logic [ACC_W:0] xe;
    logic [ACC_W:0] ye;
    logic [ACC_W:0] full;

    always_comb begin
        xe = {x[ACC_W-1], x};
        ye = {y[ACC_W-1], y};
        unique case (op)
            OP_ADD:  full = xe + ye;
            OP_SUB:  full = xe - ye;
            OP_RSUB: full = ye - xe;
            default: full = xe;
        endcase
        res  = full[ACC_W-1:0];
        wrap = full[ACC_W] ^ full[ACC_W-1];
    end
endmodule

// File: rtl/cad_window.sv
module cad_window #(
    parameter int ACC_W = 20,
    parameter int OUT_W = 16,
    parameter int SEL_W = 3
) (
    input  logic [ACC_W-1:0] res,
    input  logic [SEL_W-1:0] sel,
    output logic [OUT_W-1:0] dout,
    output logic             clip
);
    localparam int SHIFT_MAX = ACC_W - OUT_W;

    int               top;
    logic [ACC_W-1:0] mask;

    always_comb begin
        top  = ACC_W - 1 - int'(sel);
        clip = 1'b0;
        for (int i = 0; i < ACC_W; i++) begin
            if (i >= top && res[i] != res[ACC_W-1]) begin
                clip = 1'b1;
            end
        end
        mask = {ACC_W{1'b1}} >> (ACC_W - 1 - top);
        if (int'(sel) <= SHIFT_MAX) begin
            dout = OUT_W'(res >> (SHIFT_MAX - int'(sel)));
        end else begin
            dout = OUT_W'(res & mask);
        end
    end
endmodule

// File: rtl/cad_delay.sv
module cad_delay #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [DEPTH];
    logic [W-1:0] stg_q [DEPTH];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[DEPTH-1];
endmodule

// File: rtl/cplx_accum_dual.sv
module cplx_accum_dual
    import cad_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int ACC_W = 20,
    parameter int OUT_W = 16,
    parameter int SEL_W = 3,
    parameter int DLY_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  a_in,
    input  logic [IN_W-1:0]  b_in,
    input  logic             a_ce_n,
    input  logic             b_ce_n,
    input  logic [1:0]       op_re,
    input  logic [1:0]       op_im,
    input  logic             acc_clr,
    input  logic             fb_sel,
    input  logic [SEL_W-1:0] scale,
    input  logic             dly_sel,
    input  logic             oe_re_n,
    input  logic             oe_im_n,
    output logic [OUT_W-1:0] out_re,
    output logic [OUT_W-1:0] out_im,
    output logic             ovf
);
    localparam int EXT_W = ACC_W - IN_W;

    typedef struct packed {
        cad_op_e          op_re;
        cad_op_e          op_im;
        logic             clr;
        logic             fb;
        logic [SEL_W-1:0] scale;
        logic             dly;
    } ctl_t;

    typedef struct packed {
        logic [IN_W-1:0]  a;
        logic [IN_W-1:0]  b;
        ctl_t             ctl;
        logic [ACC_W-1:0] acc_re;
        logic [ACC_W-1:0] acc_im;
        logic [OUT_W-1:0] out_re;
        logic [OUT_W-1:0] out_im;
        logic             ovf;
    } state_t;

    state_t st_d, st_q;

    logic [IN_W-1:0]  a_late;
    logic [ACC_W-1:0] a_ext, b_ext, late_ext;
    logic [ACC_W-1:0] x_re, y_re, x_im, y_im;
    logic [ACC_W-1:0] sum_re, sum_im;
    logic             wrap_re, wrap_im;
    logic [OUT_W-1:0] win_re, win_im;
    logic             clip_re, clip_im;

    cad_delay #(.W(IN_W), .DEPTH(DLY_N)) u_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (st_q.a),
        .dout (a_late)
    );

    always_comb begin
        a_ext    = {{EXT_W{st_q.a[IN_W-1]}}, st_q.a};
        b_ext    = {{EXT_W{st_q.b[IN_W-1]}}, st_q.b};
        late_ext = {{EXT_W{a_late[IN_W-1]}}, a_late};
        if (st_q.ctl.fb) begin
            x_re = st_q.acc_re;
            x_im = st_q.acc_im;
        end else begin
            x_re = st_q.ctl.dly ? late_ext : a_ext;
            x_im = b_ext;
        end
        y_re = b_ext;
        y_im = a_ext;
    end

    cad_addsub #(.ACC_W(ACC_W)) u_add_re (
        .op(st_q.ctl.op_re), .x(x_re), .y(y_re), .res(sum_re), .wrap(wrap_re)
    );

    cad_addsub #(.ACC_W(ACC_W)) u_add_im (
        .op(st_q.ctl.op_im), .x(x_im), .y(y_im), .res(sum_im), .wrap(wrap_im)
    );

    cad_window #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SEL_W(SEL_W)) u_win_re (
        .res(sum_re), .sel(st_q.ctl.scale), .dout(win_re), .clip(clip_re)
    );

    cad_window #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SEL_W(SEL_W)) u_win_im (
        .res(sum_im), .sel(st_q.ctl.scale), .dout(win_im), .clip(clip_im)
    );

    always_comb begin
        st_d = st_q;
        if (!a_ce_n) st_d.a = a_in;
        if (!b_ce_n) st_d.b = b_in;
        st_d.ctl.op_re = cad_op_e'(op_re);
        st_d.ctl.op_im = cad_op_e'(op_im);
        st_d.ctl.clr   = acc_clr;
        st_d.ctl.fb    = fb_sel;
        st_d.ctl.scale = scale;
        st_d.ctl.dly   = dly_sel;
        st_d.acc_re    = st_q.ctl.clr ? '0 : sum_re;
        st_d.acc_im    = st_q.ctl.clr ? '0 : sum_im;
        st_d.out_re    = win_re;
        st_d.out_im    = win_im;
        st_d.ovf       = wrap_re | wrap_im | clip_re | clip_im;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_re = oe_re_n ? {OUT_W{1'bz}} : st_q.out_re;
    assign out_im = oe_im_n ? {OUT_W{1'bz}} : st_q.out_im;
    assign ovf    = st_q.ovf;
endmodule

// File: rtl/cplx_accum_dual_chk.sv
module cplx_accum_dual_chk #(
    parameter int IN_W  = 16,
    parameter int ACC_W = 20,
    parameter int OUT_W = 16,
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             a_ce_n,
    input logic [IN_W-1:0]  a_q,
    input logic             clr_q,
    input logic             fb_q,
    input logic [1:0]       op_re_q,
    input logic [1:0]       op_im_q,
    input logic [SEL_W-1:0] scale_q,
    input logic [ACC_W-1:0] acc_re_q,
    input logic [ACC_W-1:0] acc_im_q,
    input logic [OUT_W-1:0] out_re_q,
    input logic [OUT_W-1:0] out_im_q,
    input logic             ovf
);
    AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        a_ce_n |=> $stable(a_q)); // R2

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |=> (acc_re_q == '0 && acc_im_q == '0)); // R6

    AST_PASS_FB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_q && !clr_q && op_re_q == 2'b11) |=> $stable(acc_re_q)); // R5

    AST_FRESH_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (!fb_q && scale_q == '0) |=> !ovf); // R4

    AST_PASS_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (op_re_q == 2'b11 && op_im_q == 2'b11 && scale_q == '0) |=> !ovf); // R10

    AST_ZERO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (scale_q == 3'd7) |=> (out_re_q[OUT_W-1:OUT_W-3] == '0 && out_im_q[OUT_W-1:OUT_W-3] == '0)); // R9
endmodule

bind cplx_accum_dual cplx_accum_dual_chk #(
    .IN_W(IN_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .SEL_W(SEL_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_ce_n  (a_ce_n),
    .a_q     (st_q.a),
    .clr_q   (st_q.ctl.clr),
    .fb_q    (st_q.ctl.fb),
    .op_re_q (st_q.ctl.op_re),
    .op_im_q (st_q.ctl.op_im),
    .scale_q (st_q.ctl.scale),
    .acc_re_q(st_q.acc_re),
    .acc_im_q(st_q.acc_im),
    .out_re_q(st_q.out_re),
    .out_im_q(st_q.out_im),
    .ovf     (ovf)
);

// File: tb/cplx_accum_dual_bench.sv
`timescale 1ns/1ps
module cplx_accum_dual_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_in = '0, b_in = '0;
    logic        a_ce_n = 1'b0, b_ce_n = 1'b0;
    logic [1:0]  op_re = '0, op_im = '0;
    logic        acc_clr = 1'b0, fb_sel = 1'b0, dly_sel = 1'b0;
    logic [2:0]  scale = '0;
    logic        oe_re_n = 1'b0, oe_im_n = 1'b0;
    logic [15:0] out_re, out_im;
    logic        ovf;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cplx_accum_dual u_cplx_accum_dual (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .a_ce_n(a_ce_n), .b_ce_n(b_ce_n), .op_re(op_re), .op_im(op_im),
        .acc_clr(acc_clr), .fb_sel(fb_sel), .scale(scale), .dly_sel(dly_sel),
        .oe_re_n(oe_re_n), .oe_im_n(oe_im_n),
        .out_re(out_re), .out_im(out_im), .ovf(ovf)
    );

    typedef struct packed {
        logic [15:0] a;
        logic [15:0] b;
        logic [1:0]  ore;
        logic [1:0]  oim;
        logic [2:0]  sc;
        logic [15:0] ere;
        logic [15:0] eim;
        logic        eov;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{16'h0100, 16'h0020, 2'd0, 2'd0, 3'd4, 16'h0120, 16'h0120, 1'b0},
        '{16'h1000, 16'h0234, 2'd1, 2'd1, 3'd4, 16'h0DCC, 16'hF234, 1'b0},
        '{16'h7FFF, 16'h0001, 2'd0, 2'd3, 3'd4, 16'h8000, 16'h0001, 1'b1},
        '{16'h7FFF, 16'h0001, 2'd0, 2'd0, 3'd0, 16'h0800, 16'h0800, 1'b0},
        '{16'h8000, 16'h8000, 2'd0, 2'd0, 3'd3, 16'h8000, 16'h8000, 1'b0},
        '{16'h0123, 16'h0456, 2'd2, 2'd2, 3'd5, 16'h0333, 16'h7CCD, 1'b0},
        '{16'h2000, 16'h0000, 2'd3, 2'd3, 3'd7, 16'h0000, 16'h0000, 1'b1},
        '{16'h0ABC, 16'h1357, 2'd0, 2'd1, 3'd1, 16'h03C2, 16'h0113, 1'b0},
        '{16'h1FFF, 16'h0001, 2'd0, 2'd3, 3'd6, 16'h2000, 16'h0001, 1'b1},
        '{16'hFFFC, 16'hFFF8, 2'd1, 2'd0, 3'd2, 16'h0001, 16'hFFFD, 1'b0}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_acc();
        @(negedge clk); acc_clr = 1'b1; fb_sel = 1'b1;
        @(negedge clk); acc_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R13: reset state
        repeat (2) @(posedge clk);
        #1;
        check("R13 out_re", out_re, 16'h0000);
        check("R13 out_im", out_im, 16'h0000);
        check("R13 ovf", {15'd0, ovf}, 16'd0);
        @(negedge clk); rst_n = 1'b1;

        // R3 R4 R9 R10: vector table, fresh data only
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            a_in = VECS[i].a; b_in = VECS[i].b;
            op_re = VECS[i].ore; op_im = VECS[i].oim; scale = VECS[i].sc;
            @(posedge clk); @(posedge clk); #1;
            check($sformatf("R3/R9 vec%0d re", i), out_re, VECS[i].ere);
            check($sformatf("R3/R9 vec%0d im", i), out_im, VECS[i].eim);
            check($sformatf("R10 vec%0d ovf", i), {15'd0, ovf}, {15'd0, VECS[i].eov});
        end

        // R1 R8: latency and registered controls
        @(negedge clk); a_in = 16'd5; b_in = 16'd3; op_re = 2'd0; op_im = 2'd0; scale = 3'd4;
        @(posedge clk); @(posedge clk); #1;
        check("R1 sum after two edges", out_re, 16'd8);
        @(negedge clk); op_re = 2'd1;
        @(posedge clk); #1;
        check("R8 old op after one edge", out_re, 16'd8);
        @(posedge clk); #1;
        check("R8 new op after two edges", out_re, 16'd2);

        // R12: asynchronous output enables
        oe_re_n = 1'b1; #1;
        n_chk++;
        if (out_re === 16'd2) begin
            n_fail++;
            $display("FAIL R12 out_re disabled actual=%h expected=zzzz", out_re);
        end
        check("R12 out_im stays driven", out_im, 16'd8);
        oe_re_n = 1'b0; #1;
        check("R12 out_re re-enabled", out_re, 16'd2);

        // R2: clock enables hold
        @(negedge clk); a_in = 16'h0011; b_in = 16'h0022; op_re = 2'd0;
        @(negedge clk); a_ce_n = 1'b1; b_ce_n = 1'b1; a_in = 16'h7777; b_in = 16'h7777;
        @(posedge clk); @(posedge clk); #1;
        check("R2 re held inputs", out_re, 16'h0033);
        check("R2 im held inputs", out_im, 16'h0033);
        @(negedge clk); a_ce_n = 1'b0; b_ce_n = 1'b0;

        // R5 R6: accumulate, then clear priority
        @(negedge clk); a_in = 16'h0010; b_in = 16'h0003; op_re = 2'd0; op_im = 2'd0; scale = 3'd4;
        clear_acc();
        @(posedge clk);
        @(posedge clk); #1;
        check("R5 re acc step1", out_re, 16'd3);
        check("R5 im acc step1", out_im, 16'h0010);
        @(posedge clk); #1;
        check("R5 re acc step2", out_re, 16'd6);
        check("R5 im acc step2", out_im, 16'h0020);
        @(negedge clk); acc_clr = 1'b1;
        @(posedge clk); #1;
        check("R6 re before clear", out_re, 16'd9);
        @(negedge clk); acc_clr = 1'b0;
        @(posedge clk); #1;
        check("R6 re sum shown on clear cycle", out_re, 16'd12);
        check("R6 im sum shown on clear cycle", out_im, 16'h0040);
        @(posedge clk); #1;
        check("R6 re restart from zero", out_re, 16'd3);
        check("R6 im restart from zero", out_im, 16'h0010);

        // R11: 20-bit wrap through accumulation
        @(negedge clk); a_in = 16'h0000; b_in = 16'h7FFF; scale = 3'd0;
        clear_acc();
        @(posedge clk);
        begin
            logic [19:0] acc_m;
            logic [20:0] s;
            logic        ov_m;
            acc_m = '0;
            for (int k = 1; k <= 18; k++) begin
                @(posedge clk); #1;
                s = {acc_m[19], acc_m} + 21'd32767;
                ov_m = s[20] ^ s[19];
                acc_m = s[19:0];
                check($sformatf("R11 ovf step%0d", k), {15'd0, ovf}, {15'd0, ov_m});
                check($sformatf("R11 out step%0d", k), out_re, acc_m[19:4]);
            end
        end

        // R7: delay line on the real unit
        @(negedge clk); fb_sel = 1'b0; dly_sel = 1'b1; op_re = 2'd3; op_im = 2'd3; scale = 3'd4;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk); a_in = 16'(i * 16'h0011 + 1); b_in = 16'(i);
            @(posedge clk); #1;
            if (i >= 9) check($sformatf("R7 delayed re %0d", i), out_re, 16'((i - 9) * 16'h0011 + 1));
            if (i >= 1) check($sformatf("R7 imag undelayed %0d", i), out_im, 16'(i - 1));
        end

        finish_run();
    end
endmodule